// File: doc/BRIEF.md
# Per-CPU Interrupt Interface with Inter-Processor Signalling

This block is the slice of a multiprocessor interrupt controller that belongs to one processor. Each processor has its own copy, reached through its own 4 KiB register window. The copy for processor k sits at the controller base plus k times 0x1000, and the fabric in front of it hands over only the 12-bit offset inside that window. The block gathers three kinds of request: 32 private lines whose trigger style is set per line, level requests already routed to this processor by the global distributor, and signals raised by peer interfaces. From these it presents a single interrupt request to the core.

Software uses fixed offsets. It turns an interrupt on or off by writing its bare number to a set register or a clear register. It reads a ready register to take the lowest-numbered request that is enabled and not yet being serviced, and it writes the number back to a completion register when it is done. It raises an inter-processor interrupt by writing a target mask together with a 4-bit ID. Claim and completion are also sent out as strobes so that the distributor can follow the state of each external request.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, irq_o is low, the control register (offset 0x000) reads 0, every interrupt is disabled and every private trigger field is 0.
- R2: Bit 0 of the control register at offset 0x000 gates the interface. While it is 0, irq_o stays low, a read of the ready register returns the idle value 0x3FF and claims nothing, and claim_o does not pulse.
- R3: Writing number n to offset 0x0A0 enables interrupt n, and writing it to offset 0x0A4 disables it. Only enabled interrupts are presented. A number of NUM_IRQ (64 by default) or more written to either register changes no enable.
- R4: The trigger field of private interrupt i (0..31) is 2 bits wide and sits at offset 0x014 + 4*(i/16), bits 2*(i%16)+1 : 2*(i%16). The encodings are 0 for high level, 1 for low level, 2 for rising edge and 3 for falling edge. Both trigger words read back what was written.
- R5: A private interrupt set for level trigger is pending while its line is at the active level, high or low as configured. The line is sampled once per cycle.
- R6: A private interrupt set for edge trigger becomes pending on the configured edge and stays pending after the line returns, until that interrupt is claimed.
- R7: Among interrupts that are pending, enabled and not active, the lowest number is the ready value. If there is none, the ready value is 0x3FF. irq_o is high exactly when the ready value is not 0x3FF.
- R8: A read of offset 0x06C returns the ready value on rd_data_o one cycle after rd_en_i. When that value is not idle, the same read marks the interrupt active and pulses claim_o with its number, and the interrupt is not presented again until it is completed.
- R9: Writing number n below NUM_IRQ to offset 0x0B4 clears the active state of n and pulses eoi_o with eoi_id_o = n one cycle later. A level request that is still asserted is then presented again.
- R10: A write to offset 0x060 sends an inter-processor interrupt. Data bits 3:0 are the ID and bits 15:8 are the target mask, and mask bits at or above NUM_CPU are dropped. One cycle later ipi_vld_o pulses with ipi_mask_o and ipi_id_o, unless the remaining mask is zero, in which case nothing is sent.
- R11: ipi_req_i[p] with ID ipi_id_i[4p+3:4p] makes private interrupt ID pending until it is claimed. Several peers may signal in the same cycle. A sender that sets its own bit in the mask receives its own signal through the system loopback.
- R12: ext_irq_i[j] is interrupt 32+j and is a level-high request that is sampled once per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write offset inside the window |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Read offset inside the window |
| rd_data_o | output | DATA_W | Read data, valid one cycle after rd_en_i |
| priv_irq_i | input | 32 | Private interrupt lines 0..31 |
| ext_irq_i | input | NUM_EXT | Routed external requests, interrupt 32+j |
| ipi_req_i | input | NUM_CPU | Inter-processor signal from each peer |
| ipi_id_i | input | 4*NUM_CPU | ID carried by each peer's signal |
| irq_o | output | 1 | Interrupt request to the core |
| claim_o | output | 1 | Claim strobe |
| claim_id_o | output | 10 | Number claimed |
| eoi_o | output | 1 | Completion strobe |
| eoi_id_o | output | 10 | Number completed |
| ipi_vld_o | output | 1 | Outgoing inter-processor signal strobe |
| ipi_mask_o | output | NUM_CPU | Target processor mask |
| ipi_id_o | output | 4 | Outgoing signal ID |

## Verification
A stale or missing active bit shows up at the next read of the ready register. The read returns either the number that was just claimed again or 0x3FF where a request is waiting, and irq_o follows the same error in the cycle after the bad state is written. An edge latch that drops early, or a signal from a peer that lands in the wrong bit, lowers irq_o one cycle after the event instead of holding it until the claim. A fault in how a bare number is decoded for enable or completion is seen as irq_o staying low or high when the bench wiggles an unrelated line, or as a wrong number on eoi_id_o. The scoreboard reorders the claims to test the lowest-first rule and drives requests from several sources in the same cycle.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int unsigned ID_W    = 10;
  localparam logic [ID_W-1:0] IDLE_ID = 10'h3FF;
  localparam int unsigned PRIV_N  = 32;
  localparam int unsigned IPI_IDS = 16;
  localparam int unsigned IPI_ID_W = 4;
  localparam int unsigned MASK_LSB = 8;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_TRIG  = 12'h014;
  localparam logic [11:0] OFS_IPI   = 12'h060;
  localparam logic [11:0] OFS_READY = 12'h06C;
  localparam logic [11:0] OFS_SETEN = 12'h0A0;
  localparam logic [11:0] OFS_CLREN = 12'h0A4;
  localparam logic [11:0] OFS_EOI   = 12'h0B4;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_LOW  = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;
endpackage

// File: rtl/ciif_regs.sv
module ciif_regs
  import cpu_irq_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ),
  localparam int unsigned TRIG_W = 2 * PRIV_N
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic                iface_en_o,
  output logic [TRIG_W-1:0]   trig_o,
  output logic [NUM_IRQ-1:0]  en_o,
  output logic                eoi_hit_o,
  output logic [IDX_W-1:0]    eoi_idx_o,
  output logic                eoi_o,
  output logic [ID_W-1:0]     eoi_id_o,
  output logic                ipi_vld_o,
  output logic [NUM_CPU-1:0]  ipi_mask_o,
  output logic [IPI_ID_W-1:0] ipi_id_o
);
  localparam int unsigned TRIG_WORDS = TRIG_W / DATA_W;

  logic             num_ok;
  logic [IDX_W-1:0] num_idx;
  logic             hit_ctrl, hit_set, hit_clr, hit_ipi;
  logic [NUM_CPU-1:0] mask_in;

  assign num_ok   = wr_data_i < DATA_W'(NUM_IRQ);
  assign num_idx  = wr_data_i[IDX_W-1:0];
  assign hit_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CTRL));
  assign hit_set  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_SETEN)) && num_ok;
  assign hit_clr  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CLREN)) && num_ok;
  assign hit_ipi  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_IPI));
  assign eoi_hit_o = wr_en_i && (wr_addr_i == ADDR_W'(OFS_EOI)) && num_ok;
  assign eoi_idx_o = num_idx;
  assign mask_in  = wr_data_i[MASK_LSB +: NUM_CPU];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) iface_en_o <= 1'b0;
    else if (hit_ctrl) iface_en_o <= wr_data_i[0];
  end

  for (genvar w = 0; w < TRIG_WORDS; w++) begin : g_trig
    logic hit_w;
    assign hit_w = wr_en_i && (wr_addr_i == ADDR_W'(OFS_TRIG + 12'(4 * w)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) trig_o[w*DATA_W +: DATA_W] <= '0;
      else if (hit_w) trig_o[w*DATA_W +: DATA_W] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '0;
    else if (hit_set) en_o[num_idx] <= 1'b1;
    else if (hit_clr) en_o[num_idx] <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoi_o      <= 1'b0;
      eoi_id_o   <= '0;
      ipi_vld_o  <= 1'b0;
      ipi_mask_o <= '0;
      ipi_id_o   <= '0;
    end else begin
      eoi_o     <= eoi_hit_o;
      ipi_vld_o <= hit_ipi && (mask_in != '0);
      if (eoi_hit_o) eoi_id_o <= ID_W'(num_idx);
      if (hit_ipi) begin
        ipi_mask_o <= mask_in;
        ipi_id_o   <= wr_data_i[IPI_ID_W-1:0];
      end
    end
  end

  assert_ipi_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_vld_o |-> (ipi_mask_o != '0));
  assert_eoi_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> (eoi_id_o < ID_W'(NUM_IRQ)));
  assert_en_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (wr_addr_i == ADDR_W'(OFS_SETEN) || wr_addr_i == ADDR_W'(OFS_CLREN)))
      |=> $stable(en_o));
endmodule

// File: rtl/ciif_pending.sv
module ciif_pending
  import cpu_irq_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_EXT = 32,
  localparam int unsigned NUM_IRQ = PRIV_N + NUM_EXT,
  localparam int unsigned IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [PRIV_N-1:0]          priv_irq_i,
  input  logic [NUM_EXT-1:0]         ext_irq_i,
  input  logic [2*PRIV_N-1:0]        trig_i,
  input  logic [NUM_CPU-1:0]         ipi_req_i,
  input  logic [IPI_ID_W*NUM_CPU-1:0] ipi_id_i,
  input  logic                       clr_vld_i,
  input  logic [IDX_W-1:0]           clr_idx_i,
  output logic [NUM_IRQ-1:0]         pend_o
);
  logic [PRIV_N-1:0]  prev_q;
  logic [PRIV_N-1:0]  priv_pend;
  logic [NUM_EXT-1:0] ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      ext_q  <= '0;
    end else begin
      prev_q <= priv_irq_i;
      ext_q  <= ext_irq_i;
    end
  end

  for (genvar i = 0; i < PRIV_N; i++) begin : g_priv
    trig_e mode;
    logic  line, lvl_d, edge_ev, soft_ev, clr, lvl_r, lat_r;

    assign mode = trig_e'(trig_i[2*i +: 2]);
    assign line = priv_irq_i[i];
    assign clr  = clr_vld_i && (clr_idx_i == IDX_W'(i));

    always_comb begin
      lvl_d   = ((mode == TRIG_HIGH) && line) || ((mode == TRIG_LOW) && !line);
      edge_ev = ((mode == TRIG_RISE) && line && !prev_q[i]) ||
                ((mode == TRIG_FALL) && !line && prev_q[i]);
    end

    if (i < IPI_IDS) begin : g_soft
      always_comb begin
        soft_ev = 1'b0;
        for (int p = 0; p < NUM_CPU; p++)
          if (ipi_req_i[p] && (ipi_id_i[IPI_ID_W*p +: IPI_ID_W] == IPI_ID_W'(i)))
            soft_ev = 1'b1;
      end
    end else begin : g_nosoft
      assign soft_ev = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_r <= 1'b0;
        lat_r <= 1'b0;
      end else begin
        lvl_r <= lvl_d;
        // a new event in the claim cycle wins over the clear
        lat_r <= (lat_r && !clr) || edge_ev || soft_ev;
      end
    end

    assign priv_pend[i] = lvl_r || lat_r;

    assert_latch_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_r && !clr) |=> lat_r);
  end

  assign pend_o = {ext_q, priv_pend};

  assert_ext_level_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_irq_i[0] |=> pend_o[PRIV_N]);
endmodule

// File: rtl/ciif_select.sv
module ciif_select
  import cpu_irq_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic               iface_en_i,
  input  logic               claim_req_i,
  input  logic               eoi_hit_i,
  input  logic [IDX_W-1:0]   eoi_idx_i,
  output logic               rdy_vld_o,
  output logic [IDX_W-1:0]   rdy_idx_o,
  output logic               claim_vld_o
);
  logic [NUM_IRQ-1:0] act_q;
  logic [NUM_IRQ-1:0] cand;

  assign cand = pend_i & en_i & ~act_q & {NUM_IRQ{iface_en_i}};

  // lowest number wins
  always_comb begin
    rdy_vld_o = 1'b0;
    rdy_idx_o = '0;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (cand[k]) begin
        rdy_vld_o = 1'b1;
        rdy_idx_o = IDX_W'(k);
      end
    end
  end

  assign claim_vld_o = claim_req_i && rdy_vld_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else begin
      if (eoi_hit_i) act_q[eoi_idx_i] <= 1'b0;
      if (claim_vld_o) act_q[rdy_idx_o] <= 1'b1;
    end
  end

  assert_not_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_vld_o |-> !act_q[rdy_idx_o]);
  assert_claim_sticks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_vld_o && !(eoi_hit_i && eoi_idx_i == rdy_idx_o)) |=> act_q[$past(rdy_idx_o)]);
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpu_irq_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned NUM_EXT = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o,
  input  logic [PRIV_N-1:0]           priv_irq_i,
  input  logic [NUM_EXT-1:0]          ext_irq_i,
  input  logic [NUM_CPU-1:0]          ipi_req_i,
  input  logic [IPI_ID_W*NUM_CPU-1:0] ipi_id_i,
  output logic                        irq_o,
  output logic                        claim_o,
  output logic [ID_W-1:0]             claim_id_o,
  output logic                        eoi_o,
  output logic [ID_W-1:0]             eoi_id_o,
  output logic                        ipi_vld_o,
  output logic [NUM_CPU-1:0]          ipi_mask_o,
  output logic [IPI_ID_W-1:0]         ipi_id_o
);
  localparam int unsigned NUM_IRQ = PRIV_N + NUM_EXT;
  localparam int unsigned IDX_W   = $clog2(NUM_IRQ);
  localparam int unsigned TRIG_W  = 2 * PRIV_N;

  logic               iface_en;
  logic [TRIG_W-1:0]  trig;
  logic [NUM_IRQ-1:0] en, pend;
  logic               eoi_hit, rdy_vld, claim_vld, claim_req;
  logic [IDX_W-1:0]   eoi_idx, rdy_idx;
  logic [ID_W-1:0]    rdy_val;
  logic [DATA_W-1:0]  rd_mux;

  ciif_regs #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .iface_en_o(iface_en), .trig_o(trig), .en_o(en),
    .eoi_hit_o(eoi_hit), .eoi_idx_o(eoi_idx), .eoi_o, .eoi_id_o,
    .ipi_vld_o, .ipi_mask_o, .ipi_id_o
  );

  ciif_pending #(.NUM_CPU(NUM_CPU), .NUM_EXT(NUM_EXT)) u_pend (
    .clk_i, .rst_ni, .priv_irq_i, .ext_irq_i, .trig_i(trig),
    .ipi_req_i, .ipi_id_i, .clr_vld_i(claim_vld), .clr_idx_i(rdy_idx),
    .pend_o(pend)
  );

  ciif_select #(.NUM_IRQ(NUM_IRQ)) u_sel (
    .clk_i, .rst_ni, .pend_i(pend), .en_i(en), .iface_en_i(iface_en),
    .claim_req_i(claim_req), .eoi_hit_i(eoi_hit), .eoi_idx_i(eoi_idx),
    .rdy_vld_o(rdy_vld), .rdy_idx_o(rdy_idx), .claim_vld_o(claim_vld)
  );

  assign irq_o     = rdy_vld;
  assign rdy_val   = rdy_vld ? ID_W'(rdy_idx) : IDLE_ID;
  assign claim_req = rd_en_i && (rd_addr_i == ADDR_W'(OFS_READY));

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == ADDR_W'(OFS_CTRL)) rd_mux = DATA_W'(iface_en);
    else if (rd_addr_i == ADDR_W'(OFS_READY)) rd_mux = DATA_W'(rdy_val);
    else
      for (int w = 0; w < TRIG_W / DATA_W; w++)
        if (rd_addr_i == ADDR_W'(OFS_TRIG + 12'(4 * w))) rd_mux = trig[w*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      claim_o    <= 1'b0;
      claim_id_o <= '0;
    end else begin
      claim_o <= claim_vld;
      if (rd_en_i) rd_data_o <= rd_mux;
      if (claim_vld) claim_id_o <= ID_W'(rdy_idx);
    end
  end

  assert_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iface_en |-> !irq_o);
  assert_claim_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> (rd_data_o == DATA_W'(claim_id_o)));
  assert_idle_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_req && !irq_o) |=> (rd_data_o == DATA_W'(IDLE_ID)) && !claim_o);
endmodule

// File: tb/tb_cpu_irq_iface.sv
module tb_cpu_irq_iface;
  localparam int NUM_CPU = 4;
  localparam int NUM_EXT = 32;
  localparam int SELF    = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] priv = '0;
  logic [NUM_EXT-1:0] ext = '0;
  logic [NUM_CPU-1:0] peer_req = '0;
  logic [4*NUM_CPU-1:0] peer_id = '0;
  logic [NUM_CPU-1:0] ipi_req;
  logic [4*NUM_CPU-1:0] ipi_id;
  logic irq, claim, eoi, ipi_vld;
  logic [9:0] claim_id, eoi_id;
  logic [NUM_CPU-1:0] ipi_mask;
  logic [3:0] ipi_id_out;

  // system loopback for this processor's slot
  always_comb begin
    ipi_req = peer_req;
    ipi_id  = peer_id;
    ipi_req[SELF] = ipi_vld && ipi_mask[SELF];
    ipi_id[4*SELF +: 4] = ipi_id_out;
  end

  cpu_irq_iface #(.NUM_CPU(NUM_CPU), .NUM_EXT(NUM_EXT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .priv_irq_i(priv), .ext_irq_i(ext), .ipi_req_i(ipi_req), .ipi_id_i(ipi_id),
    .irq_o(irq), .claim_o(claim), .claim_id_o(claim_id), .eoi_o(eoi), .eoi_id_o(eoi_id),
    .ipi_vld_o(ipi_vld), .ipi_mask_o(ipi_mask), .ipi_id_o(ipi_id_out)
  );

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q = 1'b0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_q <= rd_en;

  // monitor: compares read data against the scoreboard
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) check(1, 0, "scoreboard underflow");
      else check(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  localparam logic [11:0] CTRL = 12'h000, TRIG0 = 12'h014, TRIG1 = 12'h018, SEND = 12'h060,
                          READY = 12'h06C, SETEN = 12'h0A0, CLREN = 12'h0A4, EOI = 12'h0B4;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 / R2 reset and gate
    check(irq, 0, "R1 irq after reset");
    rd(CTRL, 0, "R1 ctrl reset");
    rd(TRIG0, 0, "R1 trig reset");
    rd(READY, 32'h3FF, "R2 idle while disabled");
    check(claim, 0, "R2 no claim while disabled");
    wr(CTRL, 1);
    rd(CTRL, 1, "R2 ctrl readback");

    // R12 / R3 / R8 / R9 external level
    ext[3] = 1'b1; tick();
    check(irq, 0, "R3 not enabled");
    wr(SETEN, 35);
    check(irq, 1, "R7 irq after enable");
    rd(READY, 35, "R8 ready ext 35");
    check(claim, 1, "R8 claim strobe");
    check(claim_id, 35, "R8 claim id");
    check(irq, 0, "R8 active blocks");
    wr(EOI, 35);
    check(eoi, 1, "R9 eoi strobe");
    check(eoi_id, 35, "R9 eoi id");
    check(irq, 1, "R9 level re-presented");
    ext[3] = 1'b0; tick();
    check(irq, 0, "R12 level dropped");

    // R7 lowest first
    wr(SETEN, 40); wr(SETEN, 5);
    priv[5] = 1'b1; ext[8] = 1'b1; tick();
    rd(READY, 5, "R7 lowest first");
    rd(READY, 40, "R7 next lowest");
    check(irq, 0, "R8 both active");
    rd(READY, 32'h3FF, "R8 idle when all active");
    check(claim, 0, "R8 no claim on idle");
    priv[5] = 1'b0; tick();
    wr(EOI, 5); wr(EOI, 40);
    check(irq, 1, "R9 ext 40 back");
    wr(CLREN, 40);
    check(irq, 0, "R3 disable by number");
    ext[8] = 1'b0;

    // R3 out-of-range number
    priv[0] = 1'b1; tick();
    wr(SETEN, 64);
    check(irq, 0, "R3 number 64 ignored");
    priv[0] = 1'b0; tick();

    // R4 / R5 low level
    wr(TRIG0, 32'h10);
    rd(TRIG0, 32'h10, "R4 trig0 readback");
    wr(SETEN, 2);
    check(irq, 1, "R5 low level pending");
    rd(READY, 2, "R5 ready 2");
    priv[2] = 1'b1; tick();
    wr(EOI, 2); tick();
    check(irq, 0, "R5 low level inactive when high");

    // R6 rising
    wr(TRIG1, 32'h200);
    wr(SETEN, 20);
    priv[20] = 1'b1; tick();
    priv[20] = 1'b0; tick(); tick();
    check(irq, 1, "R6 rising edge held");
    rd(READY, 20, "R6 ready 20");
    wr(EOI, 20);
    check(irq, 0, "R6 edge consumed");

    // R6 falling
    priv[21] = 1'b1; tick();
    wr(TRIG1, 32'hE00);
    rd(TRIG1, 32'hE00, "R4 trig1 readback");
    wr(SETEN, 21);
    check(irq, 0, "R6 no falling edge yet");
    priv[21] = 1'b0; tick();
    check(irq, 1, "R6 falling edge");
    rd(READY, 21, "R6 ready 21");
    wr(EOI, 21);
    check(irq, 0, "R6 falling consumed");

    // R10 / R11 send with self in mask
    wr(SETEN, 15);
    wr(SEND, 32'hA0F);
    check(ipi_vld, 1, "R10 send strobe");
    check(ipi_mask, 4'hA, "R10 mask");
    check(ipi_id_out, 15, "R10 id");
    tick();
    check(irq, 1, "R11 self delivery");
    rd(READY, 15, "R11 ready 15");
    wr(EOI, 15);
    check(irq, 0, "R11 cleared by claim");
    wr(SEND, 32'h00F);
    check(ipi_vld, 0, "R10 empty mask");
    wr(SEND, 32'h50F);
    check(ipi_vld, 1, "R10 peers only");
    check(ipi_mask, 4'h5, "R10 mask 5");
    tick();
    check(irq, 0, "R11 not self");
    wr(SEND, 32'hF00F);
    check(ipi_vld, 0, "R10 high mask bits dropped");

    // R11 peers, simultaneous
    wr(SETEN, 7); wr(SETEN, 9); wr(SETEN, 4);
    peer_req[2] = 1'b1; peer_id[8 +: 4] = 4'd7; tick();
    peer_req = '0; tick();
    check(irq, 1, "R11 peer signal");
    rd(READY, 7, "R11 ready 7");
    wr(EOI, 7);
    check(irq, 0, "R11 peer cleared");
    peer_req[0] = 1'b1; peer_id[0 +: 4] = 4'd9;
    peer_req[3] = 1'b1; peer_id[12 +: 4] = 4'd4; tick();
    peer_req = '0;
    rd(READY, 4, "R11 two peers low");
    rd(READY, 9, "R11 two peers high");
    wr(EOI, 4); wr(EOI, 9);
    check(irq, 0, "R11 both done");

    // R2 gate while pending
    ext[3] = 1'b1; tick(); tick();
    check(irq, 1, "R2 pending before gate");
    wr(CTRL, 0);
    check(irq, 0, "R2 gated");
    rd(READY, 32'h3FF, "R2 gated read idle");
    check(claim, 0, "R2 gated no claim");
    wr(CTRL, 1);
    check(irq, 1, "R2 ungated");
    rd(READY, 35, "R2 claim after ungate");
    ext[3] = 1'b0; tick();
    wr(EOI, 35);
    check(irq, 0, "R9 final idle");

    tick(); tick();
    check(exp_q.size(), 0, "scoreboard drained");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule